// File: doc/BRIEF.md
# Bitwise Circular Convolution Unit

This block treats each of two N-bit operands as a binary sequence of length N, one sample per bit, and computes their N-point cyclic convolution. Output sample k counts the positions i where bit i of the first operand and bit ((k - i) mod N) of the second operand are both set. These are the same single-bit AND terms found in a multiplier's partial-product array. Here they are grouped by their index sum taken modulo N, not by their binary weight.

A new operand pair is accepted on any cycle where the input strobe is high. The N counts appear on the output one clock later, packed into one flat bus, with an output valid flag that mirrors the strobe. On cycles without the strobe, the registered counts keep their last value. The sequence length N is an elaboration parameter from 3 to 10. Each count is ceil(log2(N+1)) bits wide.

Top module: `cyclic_bitconv`

## Requirements
- R1: While rstN is low, and on the first edge after it rises with no strobe, outValid is 0 and every bit of sampleOut is 0.
- R2: outValid in a cycle equals the value of inValid sampled at the previous rising clock edge.
- R3: After an edge with inValid high, count field k equals the number of i in 0..N-1 for which opA[i] and opB[(k - i) mod N] are both 1.
- R4: Count field k occupies sampleOut bits [k*CW +: CW], where CW = ceil(log2(N+1)). No field ever exceeds N.
- R5: An operand pair with opA equal to zero yields zero in every count field, whatever opB holds.
- R6: On an edge with inValid low, sampleOut keeps its previous value, whatever opA and opB hold.
- R7: At N = 10, operands that are all ones give the value 10 in all ten 4-bit fields.
- R8: When opA has exactly one bit set, at position p, count field k equals opB[(k - p) mod N]. The result is opB rotated towards higher indices by p.
- R9: The sum of all count fields equals popcount(opA) times popcount(opB) of the accepted pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: accept opA and opB on this edge |
| opA | input | N | First binary sequence, bit i is sample i |
| opB | input | N | Second binary sequence, bit i is sample i |
| outValid | output | 1 | High one cycle after an accepted pair |
| sampleOut | output | N*CW | Packed counts, field k at bits [k*CW +: CW] |

## Verification
The hardest behaviour to reach from the ports is the modulo wrap of the index: the terms in which k - i goes negative and must pair with the top bits of opB. A bad wrap only shows for particular sparse bit patterns. The stimulus therefore sweeps every operand pair at N = 5, so that every wrapped pairing is driven alone. At N = 10 it walks a single set bit of opA across all positions against fixed patterns of opB, which checks the rotation of R8 at every offset. Saturating all-ones operands then push each count to its ceiling.

// File: rtl/cyclic_bitconv_pkg.sv
package cyclic_bitconv_pkg;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic load;    // capture new counts on this edge
  } ctrlStrobe_t;

  // Width of a count that must hold the values 0..n.
  function automatic int countWidth(input int n);
    return $clog2(n + 1);
  endfunction

  // Partner index in the second operand for output k and first-operand index i.
  function automatic int wrapIndex(input int k, input int i, input int n);
    return (k - i + n) % n;
  endfunction

endpackage

// File: rtl/cyclic_bitconv_ctrl.sv
module cyclic_bitconv_ctrl
  import cyclic_bitconv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobes,
  output logic        outValid
);

  logic validQ;

  always_comb begin
    strobes      = '0;
    strobes.load = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  assign outValid = validQ;

endmodule

// File: rtl/cyclic_bitconv_dp.sv
module cyclic_bitconv_dp
  import cyclic_bitconv_pkg::*;
#(
  parameter int N = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobes,
  input  logic [N-1:0]         opA,
  input  logic [N-1:0]         opB,
  output logic [N*countWidth(N)-1:0] sampleOut
);

  localparam int CW = countWidth(N);

  // termBits[k][i] is the AND term that output k receives from opA bit i.
  logic [N-1:0] termBits [N];
  logic [CW-1:0] countNext [N];
  logic [N*CW-1:0] sampleQ;

  for (genvar k = 0; k < N; k++) begin : gOut
    for (genvar i = 0; i < N; i++) begin : gTerm
      assign termBits[k][i] = opA[i] & opB[wrapIndex(k, i, N)];
    end

    always_comb begin
      countNext[k] = '0;
      for (int j = 0; j < N; j++) begin
        countNext[k] = countNext[k] + CW'(termBits[k][j]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleQ <= '0;
    end else if (strobes.load) begin
      for (int k = 0; k < N; k++) begin
        sampleQ[k*CW +: CW] <= countNext[k];
      end
    end
  end

  assign sampleOut = sampleQ;

endmodule

// File: rtl/cyclic_bitconv.sv
module cyclic_bitconv
  import cyclic_bitconv_pkg::*;
#(
  parameter int N = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [N-1:0]               opA,
  input  logic [N-1:0]               opB,
  output logic                       outValid,
  output logic [N*countWidth(N)-1:0] sampleOut
);

  ctrlStrobe_t strobes;

  cyclic_bitconv_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  cyclic_bitconv_dp #(.N(N)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .sampleOut (sampleOut)
  );

endmodule

// File: rtl/cyclic_bitconv_chk.sv
module cyclic_bitconv_chk
  import cyclic_bitconv_pkg::*;
#(
  parameter int N = 5
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       inValid,
  input logic [N-1:0]               opA,
  input logic [N-1:0]               opB,
  input logic                       outValid,
  input logic [N*countWidth(N)-1:0] sampleOut
);

  localparam int CW = countWidth(N);

  int totalOut;
  always_comb begin
    totalOut = 0;
    for (int k = 0; k < N; k++) totalOut = totalOut + int'(sampleOut[k*CW +: CW]);
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(sampleOut));  // R6
  AST_ZERO_A: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opA == '0) |=> (sampleOut == '0));  // R5
  AST_TOTAL_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (totalOut == $past($countones(opA)) * $past($countones(opB))));  // R9

  for (genvar k = 0; k < N; k++) begin : gBound
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      int'(sampleOut[k*CW +: CW]) <= N);  // R4
  end

endmodule

bind cyclic_bitconv cyclic_bitconv_chk #(.N(N)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opA       (opA),
  .opB       (opB),
  .outValid  (outValid),
  .sampleOut (sampleOut)
);

// File: tb/cyclic_bitconv_tb.sv
module cyclic_bitconv_tb_top;

  localparam int NS = 5;
  localparam int CS = 3;
  localparam int NL = 10;
  localparam int CL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vS = 1'b0, vL = 1'b0;
  logic [NS-1:0] aS = '0, bS = '0;
  logic [NL-1:0] aL = '0, bL = '0;
  logic ovS, ovL;
  logic [NS*CS-1:0] yS;
  logic [NL*CL-1:0] yL;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cyclic_bitconv #(.N(NS)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(vS), .opA(aS), .opB(bS),
    .outValid(ovS), .sampleOut(yS));

  cyclic_bitconv #(.N(NL)) dut10_i (
    .clk(clk), .rstN(rstN), .inValid(vL), .opA(aL), .opB(bL),
    .outValid(ovL), .sampleOut(yL));

  function automatic logic [39:0] refConv(input logic [9:0] a, input logic [9:0] b,
                                          input int n, input int cw);
    logic [39:0] r = '0;
    for (int k = 0; k < n; k++) begin
      int c = 0;
      for (int i = 0; i < n; i++) c += int'(a[i] & b[(k - i + n) % n]);
      r |= 40'(c) << (k * cw);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [39:0] keep;
    logic [9:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs N5", {24'd0, ovS, yS}, 40'd0);
    chk("R1 reset outputs N10", {ovL, yL}, 41'd0 >> 1);
    chk("R1 reset valid N10", {39'd0, ovL}, 40'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {24'd0, ovS, yS}, 40'd0);

    // Exhaustive sweep at N = 5
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        string tag;
        aS = 5'(a); bS = 5'(b); vS = 1'b1;
        @(negedge clk);
        if (a == 0) tag = "R5 zero opA N5";
        else if ($countones(5'(a)) == 1) tag = "R8 single bit N5";
        else tag = "R3 sweep N5";
        chk(tag, {25'd0, yS}, refConv(10'(a), 10'(b), NS, CS));
        chk("R2 valid high N5", {39'd0, ovS}, 40'd1);
      end
    end
    chk("R4 field layout N5 all ones", {25'd0, yS}, {25'd0, 3'd5, 3'd5, 3'd5, 3'd5, 3'd5});

    // Idle: inputs change but nothing is captured
    keep = {25'd0, yS};
    aS = 5'b10110; bS = 5'b01011; vS = 1'b0;
    @(negedge clk);
    chk("R6 hold N5", {25'd0, yS}, keep);
    chk("R2 valid low N5", {39'd0, ovS}, 40'd0);

    // N = 10 patterns
    aL = '1; bL = '1; vL = 1'b1;
    @(negedge clk);
    chk("R7 all ones N10", yL, {10{4'd10}});
    chk("R4 max count N10", yL, refConv(aL, bL, NL, CL));
    aL = '0; bL = '1;
    @(negedge clk);
    chk("R5 zero opA N10", yL, 40'd0);
    for (int p = 0; p < NL; p++) begin
      aL = 10'(1) << p; bL = 10'b1100101001;
      @(negedge clk);
      chk("R8 rotation N10", yL, refConv(aL, bL, NL, CL));
      aL = 10'(1) << p; bL = 10'b0000000001;
      @(negedge clk);
      chk("R8 rotation unit N10", yL, refConv(aL, bL, NL, CL));
    end
    lfsr = 10'h2A5;
    for (int t = 0; t < 200; t++) begin
      lfsr = {lfsr[8:0], lfsr[9] ^ lfsr[6]};
      aL = lfsr; bL = {lfsr[4:0], lfsr[9:5]} ^ 10'h155;
      @(negedge clk);
      chk("R3 mixed N10", yL, refConv(aL, bL, NL, CL));
      chk("R2 valid high N10", {39'd0, ovL}, 40'd1);
    end
    keep = yL;
    vL = 1'b0; aL = 10'h3FF; bL = 10'h3FF;
    @(negedge clk);
    chk("R6 hold N10", yL, keep);
    chk("R2 valid low N10", {39'd0, ovL}, 40'd0);
    @(negedge clk);
    chk("R6 hold second idle N10", yL, keep);

    summary();
  end

endmodule